// File: doc/BRIEF.md
# Buffered-Compare PWM Timer with Update Thinning

This block produces one pulse-width-modulated output from an up-counter. The counter runs from zero up to a programmable period and then starts again at zero. The output is high while the count is below a compare threshold.

The period and the threshold are each held in two copies. Software writes into a buffer, and the timer runs from an active copy. A per-register preload flag chooses when a write reaches the active copy. With the flag clear, the write lands at once. With the flag set, the write waits in the buffer until the next update event.

Update events come from counter wraps. A repetition down-counter thins them to one every N+1 wraps. A disable bit stops them entirely. Each transfer is signalled by a one-cycle strobe, so the delay from a write to its effect can be measured at the ports.

Top module: `pwm_rep_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the repetition counter, every buffer, every active copy and all control bits. While reset is held, and in the first cycle after it, `pwm_out` and `upd_evt` are 0.
- R2: A write with `wr_en`=1 selects a register by `wr_addr`. Address 0 is control: bit 0 is the compare preload flag, bit 1 is the period preload flag and bit 2 is the update disable. Address 1 is the period buffer, address 2 the compare buffer, and address 3 the repetition value, taken from the low REP_W bits. The register changes at the clock edge that samples the write.
- R3: The counter steps by one each cycle. When it equals the active period, the next value is 0 (a wrap), so one pass lasts period+1 cycles.
- R4: With the compare preload flag at 0, a compare write updates the active compare at the same edge that loads the buffer.
- R5: With the compare preload flag at 1, a compare write changes only the buffer. The active compare takes the buffer value at the next update event.
- R6: An update event occurs at a wrap when the repetition counter is 0 and the update disable bit is 0. After every event the counter reads 0.
- R7: At each wrap the repetition counter reloads from the repetition value if it is 0, and otherwise decrements. With repetition value N and no disable, events are therefore spaced (N+1)·(period+1) cycles apart.
- R8: While the update disable bit is 1, no update event occurs, no buffered value is transferred and `upd_evt` stays 0.
- R9: The period has its own preload flag and follows the same immediate-or-buffered rules as the compare.
- R10: `pwm_out` is registered. In each cycle it equals (count < active compare) as those values stood one cycle earlier. A compare of 0 keeps it low, and a compare above the period keeps it high.
- R11: `upd_evt` is high for exactly the one cycle that follows the edge at which a transfer happened. In that cycle the newly transferred values are already active.
- R12: If a buffer write and an update event fall on the same edge, the value being written is the one transferred to the active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 period, 2 compare, 3 repetition) |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Registered PWM output |
| upd_evt | output | 1 | One-cycle strobe after each update transfer |

## Verification
A software write to a preloaded buffer can land on the same edge as an update event. The two then compete for the active copy. The bench predicts the wrap edges from its own arithmetic model of the counter and repetition counter, and it places a compare write exactly on the edge where a transfer is due. It then counts the high cycles in one full period: the count must equal the freshly written threshold and not the stale buffered one. The same model is compared with both outputs in every cycle, across a sweep of thresholds, periods, repetition values and preload modes.

// File: rtl/pwm_rep_pkg.sv
package pwm_rep_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CMP    = 2'd2;
  localparam logic [1:0] ADDR_REPEAT = 2'd3;

  localparam int CTRL_CMP_PE  = 0;
  localparam int CTRL_PER_PE  = 1;
  localparam int CTRL_UPD_DIS = 2;
  localparam int CTRL_W       = 3;

  localparam int SLOT_CMP = 0;
  localparam int SLOT_PER = 1;
  localparam int N_SLOTS  = 2;
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         pe,
  input  logic         ue,
  output logic [W-1:0] act
);
  logic [W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act   <= '0;
    end else begin
      if (wr) buf_q <= wr_data;
      if (ue)
        act <= wr ? wr_data : buf_q;
      else if (wr && !pe)
        act <= wr_data;
    end
  end
endmodule

// File: rtl/pwm_rep_regs.sv
module pwm_rep_regs
  import pwm_rep_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ue,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] per_act,
  output logic [REP_W-1:0] rep_val,
  output logic             cmp_pe,
  output logic             per_pe,
  output logic             upd_dis
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [N_SLOTS-1:0] slot_wr;
  logic [N_SLOTS-1:0] slot_pe;
  logic [CNT_W-1:0]   slot_act [N_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rep_val <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL)   ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADDR_REPEAT) rep_val <= wr_data[REP_W-1:0];
    end
  end

  assign cmp_pe  = ctrl_q[CTRL_CMP_PE];
  assign per_pe  = ctrl_q[CTRL_PER_PE];
  assign upd_dis = ctrl_q[CTRL_UPD_DIS];

  assign slot_wr[SLOT_CMP] = wr_en && (wr_addr == ADDR_CMP);
  assign slot_wr[SLOT_PER] = wr_en && (wr_addr == ADDR_PERIOD);
  assign slot_pe[SLOT_CMP] = cmp_pe;
  assign slot_pe[SLOT_PER] = per_pe;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    pwm_shadow_reg #(.W(CNT_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr      (slot_wr[i]),
      .wr_data (wr_data),
      .pe      (slot_pe[i]),
      .ue      (ue),
      .act     (slot_act[i])
    );
  end

  assign cmp_act = slot_act[SLOT_CMP];
  assign per_act = slot_act[SLOT_PER];
endmodule

// File: rtl/pwm_rep_timebase.sv
module pwm_rep_timebase #(
  parameter int CNT_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] per_act,
  input  logic [REP_W-1:0] rep_val,
  input  logic             upd_dis,
  output logic [CNT_W-1:0] cnt,
  output logic             ue
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [REP_W-1:0] REP_ONE = {{(REP_W-1){1'b0}}, 1'b1};

  logic [REP_W-1:0] rep_cnt;
  logic             wrap;
  logic             rep_zero;

  assign wrap     = (cnt == per_act);
  assign rep_zero = (rep_cnt == '0);
  assign ue       = wrap && rep_zero && !upd_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rep_cnt <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + CNT_ONE;
      if (wrap) rep_cnt <= rep_zero ? rep_val : rep_cnt - REP_ONE;
    end
  end
endmodule

// File: rtl/pwm_rep_timer.sv
module pwm_rep_timer #(
  parameter int CNT_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             upd_evt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] per_act;
  logic [REP_W-1:0] rep_val;
  logic             cmp_pe;
  logic             per_pe;
  logic             upd_dis;
  logic             ue;

  pwm_rep_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ue      (ue),
    .cmp_act (cmp_act),
    .per_act (per_act),
    .rep_val (rep_val),
    .cmp_pe  (cmp_pe),
    .per_pe  (per_pe),
    .upd_dis (upd_dis)
  );

  pwm_rep_timebase #(.CNT_W(CNT_W), .REP_W(REP_W)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .per_act (per_act),
    .rep_val (rep_val),
    .upd_dis (upd_dis),
    .cnt     (cnt),
    .ue      (ue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
      upd_evt <= 1'b0;
    end else begin
      pwm_out <= (cnt < cmp_act);
      upd_evt <= ue;
    end
  end
endmodule

// File: rtl/pwm_rep_timer_chk.sv
module pwm_rep_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             upd_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] per_act,
  input logic             cmp_pe,
  input logic             per_pe,
  input logic             upd_dis
);
  // R6
  evt_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |-> (cnt == '0));

  // R8
  evt_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(upd_dis) |-> !upd_evt);

  // R5
  cmp_held_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmp_pe) && !upd_evt) |-> $stable(cmp_act));

  // R9
  per_held_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(per_pe) && !upd_evt) |-> $stable(per_act));

  // R10
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmp_act) == '0) |-> !pwm_out);
endmodule

bind pwm_rep_timer pwm_rep_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwm_out (pwm_out),
  .upd_evt (upd_evt),
  .cnt     (cnt),
  .cmp_act (cmp_act),
  .per_act (per_act),
  .cmp_pe  (cmp_pe),
  .per_pe  (per_pe),
  .upd_dis (upd_dis)
);

// File: tb/pwm_rep_timer_test.sv
module pwm_rep_timer_test;
  localparam int CNT_W = 8;
  localparam int REP_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_out;
  logic             upd_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit chk_en = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  pwm_rep_timer #(.CNT_W(CNT_W), .REP_W(REP_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .upd_evt(upd_evt)
  );

  // reference model built from the requirements
  logic [2:0]       m_ctrl;
  logic [CNT_W-1:0] m_cnt, m_per_buf, m_per_act, m_cmp_buf, m_cmp_act;
  logic [REP_W-1:0] m_rep_val, m_rep;
  logic             e_pwm, e_upd;

  function automatic bit ue_due();
    return (m_cnt == m_per_act) && (m_rep == '0) && !m_ctrl[2];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_cnt = '0; m_per_buf = '0; m_per_act = '0;
      m_cmp_buf = '0; m_cmp_act = '0; m_rep_val = '0; m_rep = '0;
      e_pwm = 1'b0; e_upd = 1'b0;
    end else begin
      automatic bit wrp = (m_cnt == m_per_act);
      automatic bit ue  = ue_due();
      automatic bit wc  = wr_en && wr_addr == 2'd2;
      automatic bit wp  = wr_en && wr_addr == 2'd1;
      e_pwm = (m_cnt < m_cmp_act);
      e_upd = ue;
      if (ue) m_cmp_act = wc ? wr_data : m_cmp_buf;
      else if (wc && !m_ctrl[0]) m_cmp_act = wr_data;
      if (ue) m_per_act = wp ? wr_data : m_per_buf;
      else if (wp && !m_ctrl[1]) m_per_act = wr_data;
      if (wc) m_cmp_buf = wr_data;
      if (wp) m_per_buf = wr_data;
      if (wrap_rep(wrp)) m_rep = (m_rep == '0) ? m_rep_val : m_rep - 1'b1;
      m_cnt = wrp ? '0 : m_cnt + 1'b1;
      if (wr_en && wr_addr == 2'd0) m_ctrl = wr_data[2:0];
      if (wr_en && wr_addr == 2'd3) m_rep_val = wr_data[REP_W-1:0];
    end
  end

  function automatic bit wrap_rep(bit w);
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !rst) begin
      chk(pwm_out === e_pwm, cur_req, int'(pwm_out), int'(e_pwm));
      chk(upd_evt === e_upd, "R11", int'(upd_evt), int'(e_upd));
    end
  end

  // caller is at a negedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[CNT_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic duty(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  task automatic gap(output int g);
    int t = 0;
    while (!upd_evt && t < 500) begin @(negedge clk); t++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!upd_evt && g < 500);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int h, g;
    repeat (3) @(negedge clk);
    chk(pwm_out === 1'b0, "R1", int'(pwm_out), 0);
    chk(upd_evt === 1'b0, "R1", int'(upd_evt), 0);
    rst = 1'b0;
    chk(pwm_out === 1'b0 && upd_evt === 1'b0, "R1", int'({pwm_out, upd_evt}), 0);
    chk_en = 1;

    // R2 R3 R4: immediate mode, period 5, compare 2
    cur_req = "R4";
    wr(2'd1, 5);
    wr(2'd2, 2);
    repeat (8) @(negedge clk);
    duty(6, h);
    chk(h == 2, "R4", h, 2);
    gap(g);
    chk(g == 6, "R3", g, 6);

    // near-exhaustive sweep
    for (int pe = 0; pe < 2; pe++)
      for (int pi = 0; pi < 2; pi++)
        for (int rp = 0; rp < 3; rp++) begin
          automatic int per = (pi == 0) ? 3 : 6;
          cur_req = pe ? "R5" : "R10";
          wr(2'd0, pe ? 3 : 0);
          wr(2'd3, rp);
          wr(2'd1, per);
          for (int c = 0; c <= per + 2; c++) begin
            wr(2'd2, c);
            repeat (2 * (rp + 1) * (per + 1) + 3) @(negedge clk);
          end
        end

    // R7: repetition thinning, period 3, repetition 2
    cur_req = "R7";
    wr(2'd0, 3);
    wr(2'd3, 2);
    wr(2'd1, 3);
    gap(g); gap(g);
    chk(g == 12, "R7", g, 12);

    // R6: repetition 0 restores an event on every wrap
    wr(2'd3, 0);
    gap(g); gap(g);
    chk(g == 4, "R6", g, 4);

    // R9: buffered period change waits for the event, then spacing follows it
    cur_req = "R9";
    wr(2'd1, 7);
    gap(g); gap(g);
    chk(g == 8, "R9", g, 8);

    // R8: disable blocks events and transfers
    cur_req = "R8";
    wr(2'd2, 3);
    gap(g);
    wr(2'd0, 7);
    wr(2'd2, 6);
    h = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (upd_evt) h++;
    end
    chk(h == 0, "R8", h, 0);
    duty(8, h);
    chk(h == 3, "R8", h, 3);
    wr(2'd0, 3);
    repeat (12) @(negedge clk);
    duty(8, h);
    chk(h == 6, "R5", h, 6);

    // R12: compare write lands on the event edge
    cur_req = "R12";
    wr(2'd1, 5);
    repeat (20) @(negedge clk);
    wr(2'd2, 1);
    repeat (14) @(negedge clk);
    while (!ue_due()) @(negedge clk);
    wr(2'd2, 4);
    chk(upd_evt === 1'b1, "R12", int'(upd_evt), 1);
    @(negedge clk);
    duty(6, h);
    chk(h == 4, "R12", h, 4);

    // R10: threshold above period keeps the output high
    cur_req = "R10";
    wr(2'd0, 0);
    wr(2'd2, 200);
    repeat (3) @(negedge clk);
    duty(12, h);
    chk(h == 12, "R10", h, 12);

    // R1: reset mid-run clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(pwm_out === 1'b0 && upd_evt === 1'b0, "R1", int'({pwm_out, upd_evt}), 0);
    repeat (4) @(negedge clk);
    chk(pwm_out === 1'b0, "R1", int'(pwm_out), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule